// File: doc/BRIEF.md
# Timer Counter with Selectable Clear

This block is one timer channel built around a 16-bit up-counter. A clock-select field sets the count rate. The rate is either one of four divisions of the system clock, taken from a free-running prescaler, or the rising edges of one of four external clock inputs, each of which is synchronised into the clock domain first.

Four compare registers, A to D, are checked against the counter whenever a count is due. A match raises that register's match flag for one cycle. A clear-select field picks which event returns the counter to zero:

- nothing;
- a match on one of the four compare registers;
- a clear request arriving from a peer channel.

Registers C and D can be marked as buffers. A buffer register never matches, so it can never clear the counter. Whenever the counter is cleared, the block emits a one-cycle clear event that peer channels can take as their own clear request.

Software configures the channel through a simple write port. A write is accepted on every cycle in which `wr_en` is high. There is no back-pressure and no read path. A parameter builds a reduced channel instead. The reduced channel has only registers A and B, and the top bit of its clear-select field is held at zero.

Top module: `tmr_clrsel_ch`

## Requirements
- R1: After reset the counter is 0, all match flags and the clear event are low, and the control word is 0 (count every clock, no clearing).
- R2: On each count enable the counter rises by exactly 1 and wraps from 65535 to 0; without an enable it holds its value.
- R3: Clock-select codes 000, 001, 010 and 011 count every clock, every 4th, every 16th and every 64th clock. The enable comes from a 6-bit prescaler that is 0 in the first cycle after reset and steps once per clock. Division by 4^k is enabled in the cycles where the low 2k prescaler bits are all ones.
- R4: Clock-select codes 100, 101, 110 and 111 count rising edges of `ext_clk[0]`, `[1]`, `[2]` and `[3]`. Each input passes through two synchronising flops. A level first sampled at clock edge n produces its count at edge n+2.
- R5: When a count is due and the counter equals compare register i, `match_o[i]` (bit 0 = A through bit 3 = D) is high for the following cycle.
- R6: Clear-select 001, 010, 101 and 110 clear on a match of A, B, C and D respectively. The counter is then loaded with 0 instead of being incremented on that count, so it runs 0..N. Codes 000 and 100 never clear.
- R7: A compare register C or D that is in buffer mode produces no match flag and never clears the counter.
- R8: With clear-select 011 or 111, the synchronous-enable bit set, and `sync_clr_in` high in a cycle, the counter is 0 in the next cycle, whether or not a count is due. With the enable bit clear, `sync_clr_in` has no effect.
- R9: `clr_evt_o` is high for exactly the one cycle after each clear of the counter, and only then.
- R10: In the reduced variant (FULL=0), the top bit of the stored clear-select is always 0, so 101 acts as 001. `match_o[3:2]` stay 0.
- R11: Address 0 holds the control word:
  - bits [2:0]: clock select;
  - bits [5:3]: clear select;
  - bit 6: synchronous enable;
  - bit 7: buffer mode for C;
  - bit 8: buffer mode for D.

  Addresses 1 to 4 hold compare registers A to D. A write takes effect at the clock edge. A count decision in the same cycle still uses the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ext_clk | input | 4 | External count inputs A to D, asynchronous |
| sync_clr_in | input | 1 | Clear request from a peer channel |
| cnt_o | output | 16 | Current counter value |
| match_o | output | 4 | One-cycle compare-match flags, A at bit 0 |
| clr_evt_o | output | 1 | One-cycle pulse after each clear of the counter |

## Verification
The assertions take for granted that the counter changes only by counting or clearing, since the block offers no direct load of the counter. They also assume that `sync_clr_in` is a plain synchronous level that is sampled once per cycle. The stimulus respects both assumptions:

- the counter is never written;
- `ext_clk` and `sync_clr_in` change only away from the active clock edge;
- `ext_clk` is toggled slowly enough that the synchroniser sees every level.

Compare values are drawn mostly from a small range, so that matches and clears actually occur within short random phases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_NSRC  = 4;
  localparam int TMR_NREG  = 4;
  localparam int TMR_AW    = 3;
  localparam int TMR_DSTEP = 2;

  localparam logic [TMR_AW-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [TMR_AW-1:0] ADDR_CMP_BASE = 3'd1;

  localparam logic [2:0] CLR_NONE0 = 3'b000;
  localparam logic [2:0] CLR_ON_A  = 3'b001;
  localparam logic [2:0] CLR_ON_B  = 3'b010;
  localparam logic [2:0] CLR_ON_C  = 3'b101;
  localparam logic [2:0] CLR_ON_D  = 3'b110;

  typedef struct packed {
    logic       buf_d;
    logic       buf_c;
    logic       sync_en;
    logic [2:0] clr_sel;
    logic [2:0] clk_sel;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NUM_DIV = 4,
  parameter int STEP    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DIV-1:0] div_en
);
  localparam int PW = STEP * (NUM_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign div_en[0] = 1'b1;
  for (genvar k = 1; k < NUM_DIV; k++) begin : g_div
    assign div_en[k] = &pre_q[STEP*k-1:0];
  end
endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ext_in,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= ext_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise[i] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit FULL  = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick,
  input  tmr_ctrl_t                         ctrl,
  input  logic [TMR_NREG-1:0][CNT_W-1:0]    cmp,
  input  logic                              sync_clr_in,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [TMR_NREG-1:0]               match_o,
  output logic                              clr_evt_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [TMR_NREG-1:0] live;
  logic [TMR_NREG-1:0] hit;
  logic                src_clr;
  logic                sync_clr;
  logic                do_clr;

  always_comb begin
    live    = '1;
    live[2] = FULL && !ctrl.buf_c;
    live[3] = FULL && !ctrl.buf_d;
  end

  for (genvar i = 0; i < TMR_NREG; i++) begin : g_cmp
    assign hit[i] = tick && live[i] && (cnt_q == cmp[i]);
  end

  always_comb begin
    unique case (ctrl.clr_sel)
      CLR_ON_A: src_clr = hit[0];
      CLR_ON_B: src_clr = hit[1];
      CLR_ON_C: src_clr = hit[2];
      CLR_ON_D: src_clr = hit[3];
      default:  src_clr = 1'b0;
    endcase
  end

  assign sync_clr = (ctrl.clr_sel[1:0] == 2'b11) && ctrl.sync_en && sync_clr_in;
  assign do_clr   = src_clr || sync_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      match_o   <= '0;
      clr_evt_o <= 1'b0;
    end else begin
      if (do_clr)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      match_o   <= hit;
      clr_evt_o <= do_clr;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_clrsel_ch.sv
module tmr_clrsel_ch
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit FULL  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [TMR_AW-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [TMR_NSRC-1:0] ext_clk,
  input  logic                sync_clr_in,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [TMR_NREG-1:0] match_o,
  output logic                clr_evt_o
);
  localparam int SEL_W = $clog2(TMR_NSRC);

  tmr_ctrl_t                     ctrl_q;
  tmr_ctrl_t                     wr_ctrl;
  logic [TMR_NREG-1:0][CNT_W-1:0] cmp_q;
  logic [TMR_NSRC-1:0]           div_en;
  logic [TMR_NSRC-1:0]           ext_rise;
  logic                          tick;

  always_comb begin
    wr_ctrl = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    if (!FULL) wr_ctrl.clr_sel[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_ctrl;
  end

  for (genvar i = 0; i < TMR_NREG; i++) begin : g_cmpreg
    localparam logic [TMR_AW-1:0] MY_ADDR = ADDR_CMP_BASE + TMR_AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cmp_q[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) cmp_q[i] <= wr_data;
    end
  end

  tmr_prescale #(.NUM_DIV(TMR_NSRC), .STEP(TMR_DSTEP)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_en (div_en)
  );

  tmr_extsync #(.N(TMR_NSRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_clk),
    .rise   (ext_rise)
  );

  assign tick = ctrl_q.clk_sel[2] ? ext_rise[ctrl_q.clk_sel[SEL_W-1:0]]
                                  : div_en[ctrl_q.clk_sel[SEL_W-1:0]];

  tmr_cnt_core #(.CNT_W(CNT_W), .FULL(FULL)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ctrl        (ctrl_q),
    .cmp         (cmp_q),
    .sync_clr_in (sync_clr_in),
    .cnt_o       (cnt_o),
    .match_o     (match_o),
    .clr_evt_o   (clr_evt_o)
  );
endmodule

// File: rtl/tmr_clrsel_ch_chk.sv
module tmr_clrsel_ch_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit FULL  = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input tmr_ctrl_t           ctrl_q,
  input logic                sync_clr_in,
  input logic [CNT_W-1:0]    cnt_o,
  input logic [TMR_NREG-1:0] match_o,
  input logic                clr_evt_o
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt_o |-> (cnt_o == '0)); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt_o |-> ((cnt_o == $past(cnt_o)) ||
                    (cnt_o == CNT_W'($past(cnt_o) + 1'b1)))); // R2

  AST_NO_CLEAR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clr_sel[1:0] == 2'b00) |=> !clr_evt_o); // R6

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sync_en && ctrl_q.clr_sel[1:0] == 2'b11 && sync_clr_in)
      |=> (cnt_o == '0 && clr_evt_o)); // R8

  AST_BUF_C_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.buf_c |=> !match_o[2]); // R7

  AST_BUF_D_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.buf_d |=> !match_o[3]); // R7

  if (!FULL) begin : g_red
    AST_RED_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.clr_sel[2] && match_o[3:2] == 2'b00); // R10
  end
endmodule

bind tmr_clrsel_ch tmr_clrsel_ch_chk #(.CNT_W(CNT_W), .FULL(FULL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_q      (ctrl_q),
  .sync_clr_in (sync_clr_in),
  .cnt_o       (cnt_o),
  .match_o     (match_o),
  .clr_evt_o   (clr_evt_o)
);

// File: tb/tmr_clrsel_ch_tb.sv
module tmr_clrsel_ch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  ext_clk = '0;
  logic        sync_clr_in = 1'b0;
  logic [15:0] cnt_f, cnt_r;
  logic [3:0]  match_f, match_r;
  logic        clr_f, clr_r;

  always #10 clk = ~clk;

  tmr_clrsel_ch #(.CNT_W(16), .FULL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .sync_clr_in(sync_clr_in),
    .cnt_o(cnt_f), .match_o(match_f), .clr_evt_o(clr_f));

  tmr_clrsel_ch #(.CNT_W(16), .FULL(1'b0)) u_red (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .sync_clr_in(sync_clr_in),
    .cnt_o(cnt_r), .match_o(match_r), .clr_evt_o(clr_r));

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [15:0] m_cnt [2];
  logic [3:0]  m_match [2];
  logic        m_clr [2];
  logic [8:0]  m_ctrl [2];
  logic [15:0] m_cmp [2][4];
  logic [5:0]  m_pre;
  logic [3:0]  m_s1, m_s2, m_s3;

  function automatic logic div_en_of(input logic [5:0] pre, input int k);
    logic [5:0] mask = 6'((1 << (2 * k)) - 1);
    return (pre & mask) == mask;
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_cnt[v] = '0; m_match[v] = '0; m_clr[v] = 1'b0; m_ctrl[v] = '0;
      for (int i = 0; i < 4; i++) m_cmp[v][i] = '0;
    end
    m_pre = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
  endtask

  task automatic compare(input string tag);
    logic [15:0] dc;
    logic [3:0]  dm;
    logic        dl;
    for (int v = 0; v < 2; v++) begin
      dc = (v == 0) ? cnt_f : cnt_r;
      dm = (v == 0) ? match_f : match_r;
      dl = (v == 0) ? clr_f : clr_r;
      vectors++;
      if (dc !== m_cnt[v] || dm !== m_match[v] || dl !== m_clr[v]) begin
        errors++;
        $display("FAIL %s inst%0d: cnt=%0d match=%b clr=%b expected cnt=%0d match=%b clr=%b",
                 tag, v, dc, dm, dl, m_cnt[v], m_match[v], m_clr[v]);
      end
    end
  endtask

  task automatic step(input string tag);
    logic [3:0]  rise = m_s2 & ~m_s3;
    logic [15:0] n_cnt [2];
    logic [3:0]  n_match [2];
    logic        n_clr [2];
    for (int v = 0; v < 2; v++) begin
      logic [2:0] sel = m_ctrl[v][2:0];
      logic [2:0] cs  = m_ctrl[v][5:3];
      logic tick, src, sc;
      logic [3:0] hit;
      tick = sel[2] ? rise[sel[1:0]] : div_en_of(m_pre, int'(sel[1:0]));
      for (int i = 0; i < 4; i++) begin
        logic alive = (i < 2) ? 1'b1 :
                      (v == 0) && !((i == 2) ? m_ctrl[v][7] : m_ctrl[v][8]);
        hit[i] = tick && alive && (m_cnt[v] == m_cmp[v][i]);
      end
      src = (cs == 3'b001 && hit[0]) || (cs == 3'b010 && hit[1]) ||
            (cs == 3'b101 && hit[2]) || (cs == 3'b110 && hit[3]);
      sc  = (cs[1:0] == 2'b11) && m_ctrl[v][6] && sync_clr_in;
      n_cnt[v]   = (src || sc) ? 16'd0 : (tick ? m_cnt[v] + 16'd1 : m_cnt[v]);
      n_match[v] = hit;
      n_clr[v]   = src || sc;
    end
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      m_cnt[v] = n_cnt[v]; m_match[v] = n_match[v]; m_clr[v] = n_clr[v];
      if (wr_en && wr_addr == 3'd0) begin
        m_ctrl[v] = wr_data[8:0];
        if (v == 1) m_ctrl[v][5] = 1'b0;
      end else if (wr_en && wr_addr >= 3'd1 && wr_addr <= 3'd4) begin
        m_cmp[v][wr_addr - 3'd1] = wr_data;
      end
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    m_pre = m_pre + 6'd1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int ext_bit, input int sync_rate, input string tag);
    for (int c = 0; c < n; c++) begin
      if (ext_bit >= 0 && (c % 3) == 0) ext_clk[ext_bit] = ~ext_clk[ext_bit];
      sync_clr_in = (sync_rate > 0) ? (($urandom % sync_rate) == 0) : 1'b0;
      step(tag);
    end
    sync_clr_in = 1'b0;
  endtask

  task automatic ctrl_word(input logic [2:0] ck, input logic [2:0] cs, input logic se,
                           input logic bc, input logic bd, input string tag);
    wr(3'd0, {7'd0, bd, bc, se, cs, ck}, tag);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    run(40, -1, 0, "R1");

    ctrl_word(3'b001, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
    run(300, -1, 0, "R3");
    ctrl_word(3'b011, 3'b100, 1'b0, 1'b0, 1'b0, "R3");
    run(400, -1, 0, "R3");

    ctrl_word(3'b101, 3'b000, 1'b0, 1'b0, 1'b0, "R4");
    run(300, 1, 0, "R4");
    ctrl_word(3'b111, 3'b000, 1'b0, 1'b0, 1'b0, "R4");
    run(300, 3, 0, "R4");

    wr(3'd1, 16'd9, "R6");
    wr(3'd2, 16'd4, "R5");
    ctrl_word(3'b000, 3'b001, 1'b0, 1'b0, 1'b0, "R6");
    run(60, -1, 0, "R6");
    ctrl_word(3'b000, 3'b010, 1'b0, 1'b0, 1'b0, "R5");
    run(60, -1, 0, "R5");

    wr(3'd3, 16'd5, "R7");
    wr(3'd4, 16'd6, "R7");
    ctrl_word(3'b000, 3'b101, 1'b0, 1'b1, 1'b0, "R7");
    run(100, -1, 0, "R7");
    ctrl_word(3'b000, 3'b110, 1'b0, 1'b0, 1'b1, "R7");
    run(100, -1, 0, "R7");
    ctrl_word(3'b000, 3'b101, 1'b0, 1'b0, 1'b0, "R10");
    run(100, -1, 0, "R10");

    ctrl_word(3'b000, 3'b011, 1'b0, 1'b0, 1'b0, "R8");
    run(200, -1, 5, "R8");
    ctrl_word(3'b010, 3'b111, 1'b1, 1'b0, 1'b0, "R8");
    run(200, -1, 7, "R8");

    ctrl_word(3'b000, 3'b000, 1'b0, 1'b0, 1'b0, "R2");
    run(65600, -1, 0, "R2");

    for (int p = 0; p < 30; p++) begin
      for (int i = 1; i <= 4; i++)
        wr(3'(i), (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % 24), "R11");
      wr(3'd0, 16'($urandom % 512), "R11");
      for (int c = 0; c < 300; c++) begin
        for (int b = 0; b < 4; b++)
          if (($urandom % 4) == 0) ext_clk[b] = ~ext_clk[b];
        sync_clr_in = (($urandom % 8) == 0);
        if (($urandom % 40) == 0) begin
          wr_en = 1'b1; wr_addr = 3'($urandom % 5); wr_data = 16'($urandom % 512);
        end
        step("R11");
        wr_en = 1'b0;
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule